// File: doc/BRIEF.md
# Shadow-Pointer Indirect Operand Redirector

This block sits between an instruction decoder and a 512-word register file. It gives existing opcodes register-indirect addressing. Four reserved register addresses, 0x1EC through 0x1EF, each own a hidden 9-bit pointer. When an operand field names one of those addresses, the register-file address the block presents is the pointer's value, not the field itself.

After reset, or after a core-start pulse, every pointer holds its own register's address. Code that never touches the pointers therefore sees the same addresses as before. Reads through a pointer cost no extra cycle.

A result write through a destination pointer that has been moved away from its own address takes two write cycles:
- First, the visible register, which serves as the cache, is written.
- In the following cycle the same result is copied to the pointed-to location.

The block raises a stall for the lost issue slot.

Top module: `shadow_redir`

## Requirements
- R1: Pointer k (k = 0..3) belongs to address 0x1EC+k. Pointers change only through the load port: `ptr_ld` high, `ptr_sel` = k, `ptr_val` = the new value. A load affects instructions issued from the following cycle on. An instruction issued in the same cycle as the load still uses the old value.
- R2: After `rst` or a `start` pulse, pointer k holds 0x1EC+k. `start` wins over a load in the same cycle. After reset, `rd_valid`, `wr_en` and `stall` are 0.
- R3: A non-immediate source field in 0x1EC..0x1EF is replaced by the value of its pointer. The redirected address appears on `src_addr` one cycle after issue, with `rd_valid` high, just as a direct address would.
- R4: A field outside 0x1EC..0x1EF appears unchanged on its address output one cycle after issue, and causes no stall.
- R5: When `src_imm` is 1, the source field is never redirected, even when its value lies in 0x1EC..0x1EF.
- R6: A destination field in 0x1EC..0x1EF is replaced on `dst_addr` by its pointer's value.
- R7: When both fields name window addresses, each one resolves through its own pointer in the same cycle.
- R8: Consider a write request whose destination lies in the window and whose pointer differs from its home address. One cycle after issue, `wr_en` = 1, `wr_addr` = the destination field and `stall` = 1. In the next cycle, `wr_en` = 1, `wr_addr` = the pointer value and `stall` = 0.
- R9: While `stall` is 1, `issue` is ignored: the next cycle shows `rd_valid` = 0 and no new write.
- R10: A write request whose destination pointer equals its home address, or whose destination lies outside the window, produces exactly one write, to the destination field, with no stall. Without a write request, `wr_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Core-start pulse that returns all pointers to their home addresses |
| issue | input | 1 | An instruction is presented this cycle |
| dst_field | input | 9 | Destination field of the instruction |
| src_field | input | 9 | Source field of the instruction |
| src_imm | input | 1 | Source field is an immediate value |
| wr_req | input | 1 | The instruction writes its result |
| ptr_ld | input | 1 | Pointer load strobe |
| ptr_sel | input | 2 | Index of the pointer to load |
| ptr_val | input | 9 | New pointer value |
| rd_valid | output | 1 | Read addresses belong to an instruction accepted in the previous cycle |
| src_addr | output | 9 | Effective source read address |
| dst_addr | output | 9 | Effective destination read address |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 9 | Result write address |
| stall | output | 1 | Issue slot lost to a redirected write copy |

## Verification
Fields are drawn from inside and outside the window, with the immediate flag both set and clear, which separates true redirection from pass-through and from the immediate exemption. Pointers are loaded both with foreign addresses and with their own home addresses, which separates the two-cycle copy write from the single write of an identity pointer. Issue pulses are kept arriving while `stall` is high, which shows that the lost slot really drops the instruction. Loads and `start` pulses that coincide with an issue or with each other pin down when a pointer change takes effect and which of the two has priority.

// File: rtl/shadow_redir_pkg.sv
package shadow_redir_pkg;
  // Phase of the result-write sequencer.
  typedef enum logic [0:0] {
    WS_IDLE = 1'b0,
    WS_COPY = 1'b1
  } wseq_t;
endpackage

// File: rtl/ptr_bank.sv
module ptr_bank #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned NPTR = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 9'h1EC,
  localparam int unsigned SEL_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   ld,
  input  logic [SEL_W-1:0]       ld_sel,
  input  logic [ADDR_W-1:0]      ld_val,
  output logic [NPTR*ADDR_W-1:0] ptrs_flat
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam logic [ADDR_W-1:0] HOME = WIN_BASE + ADDR_W'(g);
    logic [ADDR_W-1:0] p;

    always_ff @(posedge clk) begin
      if (rst || start) p <= HOME;
      else if (ld && (ld_sel == SEL_W'(g))) p <= ld_val;
    end

    assign ptrs_flat[g*ADDR_W +: ADDR_W] = p;

    // R2
    home_after_start_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> (p == HOME));

    // R1
    load_lands_chk: assert property (@(posedge clk) disable iff (rst)
      (ld && !start && (ld_sel == SEL_W'(g))) |=> (p == $past(ld_val)));
  end
endmodule

// File: rtl/addr_resolve.sv
module addr_resolve #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned NPTR = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 9'h1EC,
  localparam int unsigned SEL_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic [ADDR_W-1:0]      field,
  input  logic                   bypass,
  input  logic [NPTR*ADDR_W-1:0] ptrs_flat,
  output logic [ADDR_W-1:0]      eff,
  output logic                   hit,
  output logic                   moved
);
  localparam logic [ADDR_W-1:0] NPTR_A = ADDR_W'(NPTR);

  logic [ADDR_W-1:0] off;
  logic [SEL_W-1:0]  idx;
  logic              in_win;
  logic [ADDR_W-1:0] sel_ptr;

  assign off    = field - WIN_BASE;
  assign idx    = off[SEL_W-1:0];
  assign in_win = (field >= WIN_BASE) && (off < NPTR_A);

  always_comb begin
    sel_ptr = field;
    for (int k = 0; k < NPTR; k++) begin
      if (idx == SEL_W'(k)) sel_ptr = ptrs_flat[k*ADDR_W +: ADDR_W];
    end
  end

  assign hit   = in_win && !bypass;
  assign eff   = hit ? sel_ptr : field;
  assign moved = hit && (sel_ptr != field);
endmodule

// File: rtl/write_seq.sv
module write_seq
  import shadow_redir_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] dst_field,
  input  logic              dst_moved,
  input  logic [ADDR_W-1:0] dst_eff,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              stall
);
  wseq_t             state;
  logic [ADDR_W-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= WS_IDLE;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      stall   <= 1'b0;
      pend    <= '0;
    end else if (state == WS_COPY) begin
      // second write: copy the result to the pointed-to location
      state   <= WS_IDLE;
      wr_en   <= 1'b1;
      wr_addr <= pend;
      stall   <= 1'b0;
    end else begin
      wr_en   <= accept && wr_req;
      wr_addr <= dst_field;
      stall   <= accept && wr_req && dst_moved;
      pend    <= dst_eff;
      if (accept && wr_req && dst_moved) state <= WS_COPY;
    end
  end

  // R8
  stall_single_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  // R8
  copy_follows_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> wr_en);

  // R8
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> $past(accept && wr_req && dst_moved));
endmodule

// File: rtl/shadow_redir.sv
module shadow_redir #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned NPTR = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 9'h1EC,
  localparam int unsigned SEL_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              issue,
  input  logic [ADDR_W-1:0] dst_field,
  input  logic [ADDR_W-1:0] src_field,
  input  logic              src_imm,
  input  logic              wr_req,
  input  logic              ptr_ld,
  input  logic [SEL_W-1:0]  ptr_sel,
  input  logic [ADDR_W-1:0] ptr_val,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              stall
);
  logic [NPTR*ADDR_W-1:0] ptrs_flat;
  logic [ADDR_W-1:0]      src_eff, dst_eff;
  logic                   src_hit, src_moved, dst_hit, dst_moved;
  logic                   accept;

  assign accept = issue && !stall;

  ptr_bank #(.ADDR_W(ADDR_W), .NPTR(NPTR), .WIN_BASE(WIN_BASE)) u_ptrs (
    .clk(clk), .rst(rst), .start(start),
    .ld(ptr_ld), .ld_sel(ptr_sel), .ld_val(ptr_val),
    .ptrs_flat(ptrs_flat)
  );

  addr_resolve #(.ADDR_W(ADDR_W), .NPTR(NPTR), .WIN_BASE(WIN_BASE)) u_src_res (
    .field(src_field), .bypass(src_imm), .ptrs_flat(ptrs_flat),
    .eff(src_eff), .hit(src_hit), .moved(src_moved)
  );

  addr_resolve #(.ADDR_W(ADDR_W), .NPTR(NPTR), .WIN_BASE(WIN_BASE)) u_dst_res (
    .field(dst_field), .bypass(1'b0), .ptrs_flat(ptrs_flat),
    .eff(dst_eff), .hit(dst_hit), .moved(dst_moved)
  );

  write_seq #(.ADDR_W(ADDR_W)) u_wseq (
    .clk(clk), .rst(rst), .accept(accept), .wr_req(wr_req),
    .dst_field(dst_field), .dst_moved(dst_moved), .dst_eff(dst_eff),
    .wr_en(wr_en), .wr_addr(wr_addr), .stall(stall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      src_addr <= '0;
      dst_addr <= '0;
    end else begin
      rd_valid <= accept;
      if (accept) begin
        src_addr <= src_eff;
        dst_addr <= dst_eff;
      end
    end
  end

  // R9
  stall_drops_issue_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !rd_valid);

  // R4
  src_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (src_field < WIN_BASE)) |=> (src_addr == $past(src_field)));

  // R5
  imm_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && src_imm) |=> (src_addr == $past(src_field)));

  // R4
  dst_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (dst_field < WIN_BASE)) |=> (dst_addr == $past(dst_field) && !stall));
endmodule

// File: tb/shadow_redir_tb.sv
module shadow_redir_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst, start, issue, src_imm, wr_req, ptr_ld;
  logic [8:0] dst_field, src_field, ptr_val;
  logic [1:0] ptr_sel;
  logic       rd_valid, wr_en, stall;
  logic [8:0] src_addr, dst_addr, wr_addr;

  shadow_redir u_dut (
    .clk(clk), .rst(rst), .start(start), .issue(issue),
    .dst_field(dst_field), .src_field(src_field), .src_imm(src_imm),
    .wr_req(wr_req), .ptr_ld(ptr_ld), .ptr_sel(ptr_sel), .ptr_val(ptr_val),
    .rd_valid(rd_valid), .src_addr(src_addr), .dst_addr(dst_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .stall(stall)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [8:0] m_ptr [4];
  logic       m_valid, m_wen, m_stall, m_copy;
  logic [8:0] m_src, m_dst, m_waddr, m_pend;
  string      m_stag, m_dtag, m_wtag;

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic in_win(logic [8:0] f);
    return (f >= 9'h1EC) && (f <= 9'h1EF);
  endfunction

  function automatic logic [8:0] resolve(logic [8:0] f, logic byp);
    if (!byp && in_win(f)) return m_ptr[f[1:0]];
    return f;
  endfunction

  task automatic model_edge();
    logic acc, mv;
    if (rst) begin
      m_valid = 1'b0; m_wen = 1'b0; m_stall = 1'b0; m_copy = 1'b0;
      for (int k = 0; k < 4; k++) m_ptr[k] = 9'h1EC + 9'(k);
      return;
    end
    acc = issue && !m_stall;
    if (m_copy) begin
      m_wen = 1'b1; m_waddr = m_pend; m_wtag = "R8 copy write";
      m_copy = 1'b0; m_stall = 1'b0; m_valid = 1'b0;
    end else if (acc) begin
      m_valid = 1'b1;
      m_src = resolve(src_field, src_imm);
      m_dst = resolve(dst_field, 1'b0);
      if (src_imm) m_stag = "R5 src";
      else if (in_win(src_field) && in_win(dst_field)) m_stag = "R7 src";
      else if (in_win(src_field)) m_stag = "R3 src";
      else m_stag = "R4 src";
      m_dtag = in_win(dst_field) ? ((in_win(src_field) && !src_imm) ? "R7 dst" : "R6 dst") : "R4 dst";
      mv = wr_req && in_win(dst_field) && (m_ptr[dst_field[1:0]] != dst_field);
      m_wen = wr_req; m_waddr = dst_field;
      m_wtag = mv ? "R8 first write" : (wr_req ? "R10 write" : "R10 no write");
      m_stall = mv; m_copy = mv; m_pend = m_dst;
    end else begin
      m_valid = 1'b0; m_wen = 1'b0; m_stall = 1'b0;
      m_wtag = "R9 no write";
    end
    if (start) begin
      for (int k = 0; k < 4; k++) m_ptr[k] = 9'h1EC + 9'(k);
    end else if (ptr_ld) begin
      m_ptr[ptr_sel] = ptr_val;
    end
  endtask

  task automatic compare_all();
    chk("R9 rd_valid", {8'd0, rd_valid}, {8'd0, m_valid});
    chk("R8 stall", {8'd0, stall}, {8'd0, m_stall});
    chk(m_wtag, {8'd0, wr_en}, {8'd0, m_wen});
    if (m_valid) begin
      chk(m_stag, src_addr, m_src);
      chk(m_dtag, dst_addr, m_dst);
    end
    if (m_wen) chk({m_wtag, " addr"}, wr_addr, m_waddr);
  endtask

  task automatic cycle();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(logic iss, logic [8:0] s, logic si, logic [8:0] d, logic w,
                       logic ld, logic [1:0] sel, logic [8:0] val, logic st);
    issue = iss; src_field = s; src_imm = si; dst_field = d; wr_req = w;
    ptr_ld = ld; ptr_sel = sel; ptr_val = val; start = st;
  endtask

  task automatic idle();
    drive(1'b0, 9'd0, 1'b0, 9'd0, 1'b0, 1'b0, 2'd0, 9'd0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1;
    idle();
    @(negedge clk);
    cycle();
    cycle();
    rst = 1'b0;
    // R2: reset state of outputs
    chk("R2 reset rd_valid", {8'd0, rd_valid}, 9'd0);
    chk("R2 reset stall", {8'd0, stall}, 9'd0);
    chk("R2 reset wr_en", {8'd0, wr_en}, 9'd0);

    // R2 / R10: identity pointers, src and dst in window, write no stall
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 9'h1EC + 9'(k), 1'b0, 9'h1EF - 9'(k), 1'b1, 1'b0, 2'd0, 9'd0, 1'b0);
      cycle();
      chk("R2 identity src", src_addr, 9'h1EC + 9'(k));
      chk("R10 identity no stall", {8'd0, stall}, 9'd0);
    end

    // R1: load pointer 1 while issuing; old value still used
    drive(1'b1, 9'h1ED, 1'b0, 9'h005, 1'b0, 1'b1, 2'd1, 9'h010, 1'b0);
    cycle();
    chk("R1 same-cycle load uses old", src_addr, 9'h1ED);
    drive(1'b1, 9'h1ED, 1'b0, 9'h005, 1'b0, 1'b0, 2'd0, 9'd0, 1'b0);
    cycle();
    chk("R1 new pointer used", src_addr, 9'h010);

    // R5: immediate never redirected
    drive(1'b1, 9'h1ED, 1'b1, 9'h020, 1'b0, 1'b1, 2'd2, 9'h123, 1'b0);
    cycle();
    chk("R5 immediate src", src_addr, 9'h1ED);

    // R7 / R8 / R9: both redirected, write through moved pointer, issue during stall
    drive(1'b1, 9'h1EE, 1'b0, 9'h1ED, 1'b1, 1'b0, 2'd0, 9'd0, 1'b0);
    cycle();
    chk("R7 src own pointer", src_addr, 9'h123);
    chk("R7 dst own pointer", dst_addr, 9'h010);
    chk("R8 first write addr", wr_addr, 9'h1ED);
    chk("R8 stall raised", {8'd0, stall}, 9'd1);
    drive(1'b1, 9'h033, 1'b0, 9'h044, 1'b1, 1'b0, 2'd0, 9'd0, 1'b0);
    cycle();
    chk("R8 copy write addr", wr_addr, 9'h010);
    chk("R9 issue dropped", {8'd0, rd_valid}, 9'd0);

    // R2: start beats a load in the same cycle
    drive(1'b0, 9'd0, 1'b0, 9'd0, 1'b0, 1'b1, 2'd1, 9'h077, 1'b1);
    cycle();
    drive(1'b1, 9'h1ED, 1'b0, 9'h1EE, 1'b1, 1'b0, 2'd0, 9'd0, 1'b0);
    cycle();
    chk("R2 start over load", src_addr, 9'h1ED);
    chk("R10 identity after start", {8'd0, stall}, 9'd0);

    // R4: out-of-window pass-through
    drive(1'b1, 9'h1EB, 1'b0, 9'h1F0, 1'b1, 1'b0, 2'd0, 9'd0, 1'b0);
    cycle();
    chk("R4 src below window", src_addr, 9'h1EB);
    chk("R4 dst above window", dst_addr, 9'h1F0);
    chk("R4 no stall", {8'd0, stall}, 9'd0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] sel;
      sel = 2'($urandom % 4);
      issue     = ($urandom % 5) != 0;
      src_field = ($urandom % 2 == 0) ? 9'h1EC + 9'($urandom % 4) : 9'($urandom % 512);
      dst_field = ($urandom % 2 == 0) ? 9'h1EC + 9'($urandom % 4) : 9'($urandom % 512);
      src_imm   = ($urandom % 4) == 0;
      wr_req    = ($urandom % 3) != 0;
      ptr_ld    = ($urandom % 6) == 0;
      ptr_sel   = sel;
      ptr_val   = ($urandom % 3 == 0) ? 9'h1EC + 9'(sel) : 9'($urandom % 512);
      start     = ($urandom % 97) == 0;
      cycle();
    end

    idle();
    cycle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule